// File: doc/BRIEF.md
# Two-Bank SDRAM Command Encoder with Bank Tracker

This block sits between a memory controller's scheduler and the command pins of a two-bank synchronous DRAM. Each cycle the scheduler may present one request: mode-register load, row activate, column read, column write (each column access optionally closing its bank when the burst ends), close of one bank, close of both banks, or auto refresh. The block turns an accepted request into chip-select, row strobe, column strobe, write enable, bank select and the multiplexed address, all registered, and drives a deselect on every cycle with nothing to issue.

Alongside the encoder, a tracker keeps one open flag and one row register for each bank. It refuses any request that is illegal for the current bank state or that arrives inside a locked window: the time after a mode load, or the burst of a column access with auto close. A refused request produces a one-cycle error pulse and a deselect on the pins, and it changes no tracked state. Data movement, refresh scheduling and electrical timing other than the two lock windows are left to the surrounding controller.

Top module: `sdr_cmd_enc`

## Requirements
- R1: An accepted request appears on the pins one clock edge after it is sampled, with (cs_n, ras_n, cas_n, we_n) equal to 0000 for mode load, 0011 for activate, 0101 for read, 0100 for write, 0010 for either precharge and 0001 for refresh. The request code req_op is 0 for mode load, 1 for activate, 2 for read, 3 for write, 4 for single-bank precharge, 5 for precharge of all banks, 6 for refresh and 7 reserved.
- R2: Activate places the 10-bit row on sd_addr and the bank on sd_ba (0 is bank A, 1 is bank B). Read and write place the 8-bit column on sd_addr[7:0], drive sd_addr[8] low, drive sd_addr[9] with the auto-close flag, and select the bank on sd_ba.
- R3: A single-bank precharge drives sd_addr[9] low with the bank on sd_ba and closes only that bank. A precharge of all banks drives sd_addr = 10'h200 with sd_ba low and closes both banks. A precharge is legal in any bank state.
- R4: An activate aimed at a bank that is already open is refused.
- R5: A read or write aimed at a closed bank is refused.
- R6: Mode load and refresh are accepted only while both banks are closed. A mode load copies req_addr onto sd_addr with sd_ba low; a refresh drives sd_addr and sd_ba to zero.
- R7: After an accepted mode load, every request at the next TRSC clock edges is refused.
- R8: After an accepted read or write with auto close, every request at the next BURST_LEN clock edges is refused. The bank stays open until the last of those edges, where it closes.
- R9: Without req_valid, the pins show a deselect (all four strobes high, sd_ba and sd_addr zero) and req_err stays low. The reserved code 7 is refused.
- R10: While rst is high, the pins show a deselect, req_err is low, both banks are closed and both row registers are zero.
- R11: bank_open[b] and the row field open_rows[b*10 +: 10] change on the same edge that the changing command appears on the pins. A row register keeps the last row activated in its bank.
- R12: A refused request raises req_err for exactly the cycle in which its command would have appeared, shows a deselect on the pins, and leaves the bank flags and row registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | Request code (see R1) |
| req_bank | input | 1 | Target bank, 0 = A, 1 = B |
| req_addr | input | 10 | Row for activate, column in bits 7:0 for read/write, mode value for mode load |
| req_ap | input | 1 | Auto close after the burst, for read and write |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank select |
| sd_addr | output | 10 | Multiplexed address |
| req_err | output | 1 | Pulse: the request of the previous edge was refused |
| bank_open | output | 2 | Open flag per bank |
| open_rows | output | 20 | Row register per bank, bank b in bits b*10 +: 10 |

## Verification
Every result is due one rising edge after the request is sampled: the pin command, the error pulse and the tracker state all come from registers fed by that edge. The bench changes inputs on the falling edge and reads every output 1 ns after the following rising edge, so each check compares the edge's expected result and nothing earlier. The two lock windows are counted in edges and not in requests. Idle edges drain them as well, so the bench counts idle cycles in its model and places probes at distances 0 through TRSC+1 and 0 through BURST_LEN+1 after the locking command, which hits the last refused edge and the first accepted edge.

// File: rtl/sdr_cmd_pkg.sv
package sdr_cmd_pkg;

    typedef enum logic [2:0] {
        OP_MODE    = 3'd0,
        OP_ACT     = 3'd1,
        OP_RD      = 3'd2,
        OP_WR      = 3'd3,
        OP_PRE     = 3'd4,
        OP_PREALL  = 3'd5,
        OP_REF     = 3'd6,
        OP_RSVD    = 3'd7
    } req_op_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    localparam strobe_t STB_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    localparam int NBANK = 2;

    function automatic strobe_t op_strobes(req_op_e op);
        strobe_t s;
        s = STB_DESEL;
        case (op)
            OP_MODE:           s = '{1'b0, 1'b0, 1'b0, 1'b0};
            OP_ACT:            s = '{1'b0, 1'b0, 1'b1, 1'b1};
            OP_RD:             s = '{1'b0, 1'b1, 1'b0, 1'b1};
            OP_WR:             s = '{1'b0, 1'b1, 1'b0, 1'b0};
            OP_PRE, OP_PREALL: s = '{1'b0, 1'b0, 1'b1, 1'b0};
            OP_REF:            s = '{1'b0, 1'b0, 1'b0, 1'b1};
            default:           s = STB_DESEL;
        endcase
        return s;
    endfunction

    function automatic logic is_column(req_op_e op);
        return (op == OP_RD) || (op == OP_WR);
    endfunction

endpackage

// File: rtl/sdr_req_check.sv
module sdr_req_check
    import sdr_cmd_pkg::*;
(
    input  logic             req_valid,
    input  req_op_e          op,
    input  logic             bank,
    input  logic             ap,
    input  logic [NBANK-1:0] bank_open,
    input  logic             locked,
    output logic             issue,
    output logic             refuse,
    output logic             mode_start,
    output logic             ap_start
);
    logic legal;
    logic any_open;

    assign any_open = |bank_open;

    always_comb begin
        legal = 1'b0;
        case (op)
            OP_MODE, OP_REF:   legal = !any_open;
            OP_ACT:            legal = !bank_open[bank];
            OP_RD, OP_WR:      legal = bank_open[bank];
            OP_PRE, OP_PREALL: legal = 1'b1;
            default:           legal = 1'b0;
        endcase
    end

    assign issue      = req_valid && !locked && legal;
    assign refuse     = req_valid && !issue;
    assign mode_start = issue && (op == OP_MODE);
    assign ap_start   = issue && is_column(op) && ap;
endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track
    import sdr_cmd_pkg::*;
#(
    parameter int ROW_W     = 10,
    parameter int BURST_LEN = 4,
    parameter int TRSC      = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   issue,
    input  req_op_e                op,
    input  logic                   bank,
    input  logic [ROW_W-1:0]       row,
    input  logic                   mode_start,
    input  logic                   ap_start,
    output logic [NBANK-1:0]       bank_open,
    output logic [NBANK*ROW_W-1:0] open_rows,
    output logic                   locked
);
    localparam int LOCK_MAX = (BURST_LEN > TRSC) ? BURST_LEN : TRSC;
    localparam int LOCK_W   = $clog2(LOCK_MAX + 1);

    logic [LOCK_W-1:0] lock_q;
    logic              pend_q;
    logic              pend_bank_q;
    logic              lock_last;

    assign locked    = (lock_q != '0);
    assign lock_last = (lock_q == LOCK_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q      <= '0;
            pend_q      <= 1'b0;
            pend_bank_q <= 1'b0;
        end else if (locked) begin
            lock_q <= lock_q - LOCK_W'(1);
            if (lock_last) begin
                pend_q <= 1'b0;
            end
        end else if (mode_start) begin
            lock_q <= LOCK_W'(TRSC);
        end else if (ap_start) begin
            lock_q      <= LOCK_W'(BURST_LEN);
            pend_q      <= 1'b1;
            pend_bank_q <= bank;
        end
    end

    for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
        logic             open_r;
        logic [ROW_W-1:0] row_r;
        logic             hit;
        logic             act_here;
        logic             pre_here;
        logic             auto_here;

        assign hit       = (bank == gb[0]);
        assign act_here  = issue && (op == OP_ACT) && hit;
        assign pre_here  = issue && (((op == OP_PRE) && hit) || (op == OP_PREALL));
        assign auto_here = lock_last && pend_q && (pend_bank_q == gb[0]);

        always_ff @(posedge clk) begin
            if (rst) begin
                open_r <= 1'b0;
                row_r  <= '0;
            end else if (act_here) begin
                open_r <= 1'b1;
                row_r  <= row;
            end else if (pre_here || auto_here) begin
                open_r <= 1'b0;
            end
        end

        assign bank_open[gb]                 = open_r;
        assign open_rows[gb*ROW_W +: ROW_W]  = row_r;
    end
endmodule

// File: rtl/sdr_pin_encode.sv
module sdr_pin_encode
    import sdr_cmd_pkg::*;
#(
    parameter int ROW_W = 10,
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  req_op_e          op,
    input  logic             bank,
    input  logic [ROW_W-1:0] addr,
    input  logic             ap,
    output strobe_t          stb,
    output logic             ba,
    output logic [ROW_W-1:0] a
);
    localparam int AP_BIT = ROW_W - 1;

    logic [ROW_W-1:0] a_next;
    logic             ba_next;

    always_comb begin
        a_next  = '0;
        ba_next = 1'b0;
        case (op)
            OP_MODE: a_next = addr;
            OP_ACT: begin
                a_next  = addr;
                ba_next = bank;
            end
            OP_RD, OP_WR: begin
                a_next[COL_W-1:0] = addr[COL_W-1:0];
                a_next[AP_BIT]    = ap;
                ba_next           = bank;
            end
            OP_PRE:    ba_next = bank;
            OP_PREALL: a_next[AP_BIT] = 1'b1;
            default: begin
                a_next  = '0;
                ba_next = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !issue) begin
            stb <= STB_DESEL;
            ba  <= 1'b0;
            a   <= '0;
        end else begin
            stb <= op_strobes(op);
            ba  <= ba_next;
            a   <= a_next;
        end
    end
endmodule

// File: rtl/sdr_cmd_enc.sv
module sdr_cmd_enc
    import sdr_cmd_pkg::*;
#(
    parameter int ROW_W     = 10,
    parameter int COL_W     = 8,
    parameter int BURST_LEN = 4,
    parameter int TRSC      = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [2:0]             req_op,
    input  logic                   req_bank,
    input  logic [ROW_W-1:0]       req_addr,
    input  logic                   req_ap,
    output logic                   sd_cs_n,
    output logic                   sd_ras_n,
    output logic                   sd_cas_n,
    output logic                   sd_we_n,
    output logic                   sd_ba,
    output logic [ROW_W-1:0]       sd_addr,
    output logic                   req_err,
    output logic [1:0]             bank_open,
    output logic [2*ROW_W-1:0]     open_rows
);
    req_op_e          op_in;
    logic             issue;
    logic             refuse;
    logic             mode_start;
    logic             ap_start;
    logic             locked;
    strobe_t          stb;
    logic             err_q;

    assign op_in = req_op_e'(req_op);

    sdr_req_check u_check (
        .req_valid  (req_valid),
        .op         (op_in),
        .bank       (req_bank),
        .ap         (req_ap),
        .bank_open  (bank_open),
        .locked     (locked),
        .issue      (issue),
        .refuse     (refuse),
        .mode_start (mode_start),
        .ap_start   (ap_start)
    );

    sdr_bank_track #(
        .ROW_W     (ROW_W),
        .BURST_LEN (BURST_LEN),
        .TRSC      (TRSC)
    ) u_track (
        .clk        (clk),
        .rst        (rst),
        .issue      (issue),
        .op         (op_in),
        .bank       (req_bank),
        .row        (req_addr),
        .mode_start (mode_start),
        .ap_start   (ap_start),
        .bank_open  (bank_open),
        .open_rows  (open_rows),
        .locked     (locked)
    );

    sdr_pin_encode #(
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_pins (
        .clk   (clk),
        .rst   (rst),
        .issue (issue),
        .op    (op_in),
        .bank  (req_bank),
        .addr  (req_addr),
        .ap    (req_ap),
        .stb   (stb),
        .ba    (sd_ba),
        .a     (sd_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= refuse;
    end

    assign sd_cs_n  = stb.cs_n;
    assign sd_ras_n = stb.ras_n;
    assign sd_cas_n = stb.cas_n;
    assign sd_we_n  = stb.we_n;
    assign req_err  = err_q;
endmodule

// File: rtl/sdr_cmd_enc_chk.sv
module sdr_cmd_enc_chk #(
    parameter int ROW_W = 10
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               sd_cs_n,
    input logic               sd_ras_n,
    input logic               sd_cas_n,
    input logic               sd_we_n,
    input logic               sd_ba,
    input logic [ROW_W-1:0]   sd_addr,
    input logic               req_err,
    input logic [1:0]         bank_open,
    input logic [2*ROW_W-1:0] open_rows
);
    logic on_act, on_col, on_mode, on_pre;

    assign on_act  = !sd_cs_n && !sd_ras_n &&  sd_cas_n &&  sd_we_n;
    assign on_col  = !sd_cs_n &&  sd_ras_n && !sd_cas_n;
    assign on_mode = !sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n;
    assign on_pre  = !sd_cs_n && !sd_ras_n &&  sd_cas_n && !sd_we_n;

    // R11: activate on the pins coincides with the tracker showing that row open
    a_r11_act_tracks: assert property (@(posedge clk) disable iff (rst)
        on_act |-> (bank_open[sd_ba] && (open_rows[sd_ba*ROW_W +: ROW_W] == sd_addr)));

    // R5: a column command only ever reaches an open bank
    a_r5_col_open: assert property (@(posedge clk) disable iff (rst)
        on_col |-> bank_open[sd_ba]);

    // R6: mode load only with every bank closed
    a_r6_mode_idle: assert property (@(posedge clk) disable iff (rst)
        on_mode |-> (bank_open == 2'b00));

    // R3: a precharge leaves its target bank(s) closed
    a_r3_pre_closes: assert property (@(posedge clk) disable iff (rst)
        on_pre |-> (sd_addr[ROW_W-1] ? (bank_open == 2'b00) : !bank_open[sd_ba]));

    // R12: a refusal never puts a command on the pins
    a_r12_refuse_desel: assert property (@(posedge clk) disable iff (rst)
        req_err |-> sd_cs_n);

    // R9: no request gives a deselect and no error
    a_r9_idle_desel: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(req_valid)) |-> (sd_cs_n && !req_err));

    // R7: the edge after a mode load carries no command
    a_r7_mode_lock: assert property (@(posedge clk) disable iff (rst)
        on_mode |=> sd_cs_n);
endmodule

bind sdr_cmd_enc sdr_cmd_enc_chk #(.ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_ba     (sd_ba),
    .sd_addr   (sd_addr),
    .req_err   (req_err),
    .bank_open (bank_open),
    .open_rows (open_rows)
);

// File: tb/sdr_cmd_enc_tb.sv
`timescale 1ns/1ps
module sdr_cmd_enc_tb;
    localparam int ROW_W = 10;
    localparam int BURST = 4;
    localparam int TRSC  = 2;

    logic clk = 1'b0;
    logic rst;
    logic req_valid;
    logic [2:0] req_op;
    logic req_bank;
    logic [ROW_W-1:0] req_addr;
    logic req_ap;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba;
    logic [ROW_W-1:0] sd_addr;
    logic req_err;
    logic [1:0] bank_open;
    logic [2*ROW_W-1:0] open_rows;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit m_open [2];
    logic [ROW_W-1:0] m_row [2];
    int m_lock;
    bit m_pend;
    bit m_pbank;

    always #4 clk = ~clk;

    sdr_cmd_enc #(.ROW_W(ROW_W), .COL_W(8), .BURST_LEN(BURST), .TRSC(TRSC)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .req_addr(req_addr), .req_ap(req_ap),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .req_err(req_err),
        .bank_open(bank_open), .open_rows(open_rows)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input bit v, input int op, input bit b, input logic [ROW_W-1:0] a, input bit ap);
        logic [3:0] es;
        bit eba;
        logic [ROW_W-1:0] ea;
        bit eerr;
        bit acc;
        string tag;
        es = 4'hF; eba = 0; ea = '0; eerr = 0; acc = 0; tag = "R9";
        if (v) begin
            if (m_lock > 0) begin
                eerr = 1; tag = "R7/R8";
            end else begin
                case (op)
                    0: if (m_open[0] || m_open[1]) begin eerr = 1; tag = "R6"; end
                       else begin acc = 1; es = 4'b0000; ea = a; tag = "R6"; end
                    1: if (m_open[b]) begin eerr = 1; tag = "R4"; end
                       else begin acc = 1; es = 4'b0011; eba = b; ea = a; tag = "R2"; end
                    2, 3: if (!m_open[b]) begin eerr = 1; tag = "R5"; end
                       else begin
                           acc = 1; es = (op == 2) ? 4'b0101 : 4'b0100; eba = b;
                           ea = {ap, 1'b0, a[7:0]}; tag = ap ? "R8" : "R2";
                       end
                    4: begin acc = 1; es = 4'b0010; eba = b; tag = "R3"; end
                    5: begin acc = 1; es = 4'b0010; ea = 10'h200; tag = "R3"; end
                    6: if (m_open[0] || m_open[1]) begin eerr = 1; tag = "R6"; end
                       else begin acc = 1; es = 4'b0001; tag = "R6"; end
                    default: begin eerr = 1; tag = "R9"; end
                endcase
            end
        end
        if (m_lock > 0) begin
            if (m_lock == 1 && m_pend) begin m_open[m_pbank] = 0; m_pend = 0; end
            m_lock--;
        end else if (acc) begin
            case (op)
                0: m_lock = TRSC;
                1: begin m_open[b] = 1; m_row[b] = a; end
                2, 3: if (ap) begin m_lock = BURST; m_pend = 1; m_pbank = b; end
                4: m_open[b] = 0;
                5: begin m_open[0] = 0; m_open[1] = 0; end
                default: ;
            endcase
        end
        @(negedge clk);
        req_valid = v; req_op = op[2:0]; req_bank = b; req_addr = a; req_ap = ap;
        @(posedge clk);
        #1;
        check({"R1/", tag, " strobes"}, {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, {28'd0, es});
        check({tag, " bank/addr"}, {21'd0, sd_ba, sd_addr}, {21'd0, eba, ea});
        check({eerr ? "R12/" : "", tag, " err"}, {31'd0, req_err}, {31'd0, eerr});
        check("R11 open", {30'd0, bank_open}, {30'd0, m_open[1], m_open[0]});
        check("R11 rows", {12'd0, open_rows}, {12'd0, m_row[1], m_row[0]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; req_valid = 0; req_op = 0; req_bank = 0; req_addr = '0; req_ap = 0;
        m_open[0] = 0; m_open[1] = 0; m_row[0] = '0; m_row[1] = '0;
        m_lock = 0; m_pend = 0; m_pbank = 0;
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        check("R10 strobes", {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'hF);
        check("R10 err", {31'd0, req_err}, 32'd0);
        check("R10 open", {30'd0, bank_open}, 32'd0);
        check("R10 rows", {12'd0, open_rows}, 32'd0);
        @(negedge clk);
        rst = 0;

        for (int s = 0; s < 4; s++)
            for (int op = 0; op < 8; op++)
                for (int b = 0; b < 2; b++)
                    for (int ap = 0; ap < 2; ap++) begin
                        logic [ROW_W-1:0] a;
                        a = ROW_W'((op * 97 + b * 311 + ap * 53 + s * 17 + 5) & 10'h3ff);
                        cyc(1, 5, 0, '0, 0);
                        if (s[0]) cyc(1, 1, 0, a ^ 10'h155, 0);
                        if (s[1]) cyc(1, 1, 1, a ^ 10'h2aa, 0);
                        cyc(1, op, b[0], a, ap[0]);
                        cyc(1, 2, b[0], a, 0);
                        repeat (6) cyc(0, 0, 0, '0, 0);
                    end

        // R8 boundary: lock after write with auto close
        for (int d = 0; d <= BURST + 1; d++) begin
            cyc(1, 5, 0, '0, 0);
            cyc(1, 1, 0, 10'h3c3, 0);
            cyc(1, 3, 0, 10'h0a5, 1);
            repeat (d) cyc(0, 0, 0, '0, 0);
            cyc(1, 1, 0, 10'h111, 0);
            repeat (6) cyc(0, 0, 0, '0, 0);
        end
        // R7 boundary: lock after mode load
        for (int d = 0; d <= TRSC + 1; d++) begin
            cyc(1, 5, 0, '0, 0);
            cyc(1, 0, 0, 10'h237, 0);
            repeat (d) cyc(0, 0, 0, '0, 0);
            cyc(1, 1, 1, 10'h0f0, 0);
            repeat (4) cyc(0, 0, 0, '0, 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule